// File: doc/BRIEF.md
# Chained Descriptor DMA Controller

This block moves blocks of dwords between host memory and local memory by working through a table of descriptors that software places in host memory. Software programs four write-only registers. The first holds the number of descriptors in the table and three mode bits. The next two hold the table's host address. The last holds the index of the final descriptor to run. Writing that last register starts the engine.

The engine fetches each four-dword descriptor in turn. It splits the descriptor's transfer into bursts on a generic memory-request port. After each descriptor it can write the completed index back to host memory. After the final descriptor it can raise a one-cycle interrupt request. A status word shows whether descriptors are still pending and which descriptor finished last. The memory side is a request/accept handshake. Fetch data returns one dword per beat, and a done pulse closes each request.

Top module: `desc_dma`

## Requirements
- R1: After reset the status word reads 0x0001FFFF: bit 16 is 1, meaning idle, and the completed index is 0xFFFF, meaning none yet. No request is raised and `irq` is low.
- R2: Register writes use `reg_sel` as follows. Select 0 holds the descriptor count in bits 15:0, the direction in bit 16, the write-back enable in bit 17 and the interrupt enable in bit 18. Select 1 holds the upper 32 bits of the table address. Select 2 holds the lower 32 bits of the table address. Select 3 holds the last index in bits 15:0.
- R3: Descriptor i is fetched from table + 16·i with op 0 and length 4. Its beats arrive in order:
  - dword 0: length in dwords, in bits 15:0
  - dword 1: local address
  - dword 2: upper 32 bits of the host address
  - dword 3: lower 32 bits of the host address
- R4: Data bursts carry at most 32 dwords each. Both addresses advance by 4 bytes per dword from one burst to the next, and the final burst carries the remainder. A 1024-dword descriptor therefore gives 32 bursts.
- R5: Direction bit 0 gives op 1 (host to local) and direction bit 1 gives op 2 (local to host). The bit is sampled when the descriptor is loaded.
- R6: Bits 1:0 of every host and local address on the request port are zero. Address bits 1:0 written by software or found in a descriptor are ignored.
- R7: A write to select 3 while idle starts the chain at index 0 when the count is nonzero. The engine processes indices 0 through the last index inclusive. A last index at or above the count is clamped to count−1. A write while the count is zero is ignored.
- R8: Status bit 16 is 0 while descriptors are pending. Status bits 15:0 hold the index of the most recently completed descriptor.
- R9: With write-back enabled, each descriptor is followed by a one-dword write (op 3) of its index to address table−4. With write-back disabled, no such write is made.
- R10: With the interrupt enabled, `irq` pulses for exactly one cycle when the chain ends, and the status word reads idle in that same cycle. With the interrupt disabled, `irq` never pulses.
- R11: A write to select 3 while busy moves the stopping point of the running chain. The chain is not restarted from index 0.
- R12: A descriptor of length 0 issues no data burst and still counts as completed.
- R13: A request keeps its op, addresses and length stable until `mem_req_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| stat_word | output | 32 | Bit 16 idle, bits 15:0 last completed index |
| irq | output | 1 | End-of-chain interrupt pulse |
| mem_req_valid | output | 1 | Request present |
| mem_req_ready | input | 1 | Request accepted this cycle |
| mem_req_op | output | 2 | 0 fetch, 1 host-to-local, 2 local-to-host, 3 write-back |
| mem_req_haddr | output | 64 | Host byte address |
| mem_req_laddr | output | 32 | Local byte address (data bursts) |
| mem_req_len | output | 6 | Length in dwords |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rd_valid | input | 1 | Fetch data beat valid |
| mem_rd_data | input | 32 | Fetch data beat |
| mem_done | input | 1 | Request completed; arrives after the last fetch beat |

## Verification
The hardest case to reach is a chain extension. The stop index must be rewritten while the engine is deep inside a long descriptor, and the engine must carry on to new descriptors without fetching index 0 again. The stimulus starts a run whose only descriptor is 1024 dwords long, so the run lasts many bursts. It then rewrites the last index partway through. A reference queue receives the added fetches and bursts before the rewrite, so any refetch shows up as a mismatch. The memory responder also stalls acceptance by a varying number of cycles to check that requests are held.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int IDX_W      = 16;
    localparam int DESC_WORDS = 4;

    typedef enum logic [1:0] {
        OP_FETCH = 2'd0,
        OP_H2L   = 2'd1,
        OP_L2H   = 2'd2,
        OP_WB    = 2'd3
    } mem_op_e;

    // word 0 in the low bits, word 3 in the high bits
    typedef struct packed {
        logic [31:0] host_lo;
        logic [31:0] host_hi;
        logic [31:0] loc;
        logic [31:0] ctl;
    } desc_t;

    typedef struct packed {
        logic [IDX_W-1:0] count;
        logic             dir;
        logic             wb_en;
        logic             irq_en;
    } cfg_t;

    typedef enum logic [3:0] {
        S_IDLE, S_FREQ, S_FWAIT, S_LOAD, S_XREQ,
        S_XWAIT, S_DDONE, S_WREQ, S_WWAIT, S_NEXT
    } seq_state_e;

    function automatic logic [IDX_W-1:0] clamp_last(input logic [IDX_W-1:0] want,
                                                    input logic [IDX_W-1:0] cnt);
        return (want >= cnt) ? cnt - IDX_W'(1) : want;
    endfunction

    function automatic int unsigned chunk(input int unsigned rem, input int unsigned cap);
        return (rem > cap) ? cap : rem;
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [31:0]      wdata,
    input  logic             busy,
    output cfg_t             cfg,
    output logic [63:0]      tbase,
    output logic [IDX_W-1:0] limit,
    output logic             start
);
    cfg_t             cfg_q;
    logic [31:0]      thi_q;
    logic [31:2]      tlo_q;
    logic [IDX_W-1:0] lim_q;
    logic             last_wr;
    logic [IDX_W-1:0] lim_new;

    assign last_wr = we && (sel == 2'd3) && (cfg_q.count != '0);
    assign lim_new = clamp_last(wdata[IDX_W-1:0], cfg_q.count);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            thi_q <= '0;
            tlo_q <= '0;
            lim_q <= '0;
        end else if (we) begin
            case (sel)
                2'd0: cfg_q <= '{count: wdata[IDX_W-1:0], dir: wdata[16],
                                 wb_en: wdata[17], irq_en: wdata[18]};
                2'd1: thi_q <= wdata;
                2'd2: tlo_q <= wdata[31:2];
                default: if (last_wr) lim_q <= lim_new;
            endcase
        end
    end

    assign cfg   = cfg_q;
    assign tbase = {thi_q, tlo_q, 2'b00};
    assign limit = last_wr ? lim_new : lim_q;
    assign start = last_wr && !busy;

endmodule

// File: rtl/dma_desc_cap.sv
module dma_desc_cap
    import dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        rd_valid,
    input  logic [31:0] rd_data,
    output desc_t       desc
);
    logic [DESC_WORDS-1:0][31:0]     words;
    logic [$clog2(DESC_WORDS)-1:0]   beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            words <= '0;
            beat  <= '0;
        end else if (clr) begin
            beat <= '0;
        end else if (rd_valid) begin
            words[beat] <= rd_data;
            beat        <= beat + 1'b1;
        end
    end

    assign desc = desc_t'(words);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MAX_BURST = 32,
    parameter int BLEN_W    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  limit,
    input  cfg_t              cfg,
    input  logic [63:0]       tbase,
    input  desc_t             desc,
    input  logic              req_ready,
    input  logic              done,
    output logic              req_valid,
    output mem_op_e           req_op,
    output logic [63:0]       req_haddr,
    output logic [31:0]       req_laddr,
    output logic [BLEN_W-1:0] req_len,
    output logic [31:0]       req_wdata,
    output logic              busy,
    output logic              fetch_go,
    output logic [IDX_W-1:0]  last_done,
    output logic              irq
);
    seq_state_e        state;
    logic [IDX_W-1:0]  cur;
    logic [LEN_W-1:0]  rem;
    logic [63:0]       hw;
    logic [31:0]       lw;
    logic              dir_w;
    logic              irq_q;
    logic [IDX_W-1:0]  last_q;
    logic [BLEN_W-1:0] blen;
    logic [LEN_W-1:0]  dlen;

    assign blen = BLEN_W'(chunk(32'(rem), MAX_BURST));
    assign dlen = desc.ctl[LEN_W-1:0];

    logic unused_bits;
    assign unused_bits = ^{desc.ctl[31:LEN_W], desc.loc[1:0], desc.host_lo[1:0], cfg.count};

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            cur    <= '0;
            rem    <= '0;
            hw     <= '0;
            lw     <= '0;
            dir_w  <= 1'b0;
            irq_q  <= 1'b0;
            last_q <= '1;
        end else begin
            irq_q <= 1'b0;
            case (state)
                S_IDLE:  if (start) begin cur <= '0; state <= S_FREQ; end
                S_FREQ:  if (req_ready) state <= S_FWAIT;
                S_FWAIT: if (done) state <= S_LOAD;
                S_LOAD: begin
                    rem   <= dlen;
                    hw    <= {desc.host_hi, desc.host_lo[31:2], 2'b00};
                    lw    <= {desc.loc[31:2], 2'b00};
                    dir_w <= cfg.dir;
                    state <= (dlen == '0) ? S_DDONE : S_XREQ;
                end
                S_XREQ: if (req_ready) begin
                    rem   <= rem - LEN_W'(blen);
                    hw    <= hw + (64'(blen) << 2);
                    lw    <= lw + (32'(blen) << 2);
                    state <= S_XWAIT;
                end
                S_XWAIT: if (done) state <= (rem == '0) ? S_DDONE : S_XREQ;
                S_DDONE: begin
                    last_q <= cur;
                    state  <= cfg.wb_en ? S_WREQ : S_NEXT;
                end
                S_WREQ:  if (req_ready) state <= S_WWAIT;
                S_WWAIT: if (done) state <= S_NEXT;
                S_NEXT: begin
                    if (cur >= limit) begin
                        irq_q <= cfg.irq_en;
                        state <= S_IDLE;
                    end else begin
                        cur   <= cur + 1'b1;
                        state <= S_FREQ;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req_valid = 1'b0;
        req_op    = OP_FETCH;
        req_haddr = '0;
        req_laddr = '0;
        req_len   = '0;
        req_wdata = '0;
        case (state)
            S_FREQ: begin
                req_valid = 1'b1;
                req_haddr = tbase + (64'(cur) << 4);
                req_len   = BLEN_W'(DESC_WORDS);
            end
            S_XREQ: begin
                req_valid = 1'b1;
                req_op    = dir_w ? OP_L2H : OP_H2L;
                req_haddr = hw;
                req_laddr = lw;
                req_len   = blen;
            end
            S_WREQ: begin
                req_valid = 1'b1;
                req_op    = OP_WB;
                req_haddr = tbase - 64'd4;
                req_len   = BLEN_W'(1);
                req_wdata = 32'(cur);
            end
            default: ;
        endcase
    end

    assign busy      = (state != S_IDLE);
    assign fetch_go  = (state == S_FREQ) && req_ready;
    assign last_done = last_q;
    assign irq       = irq_q;

endmodule

// File: rtl/desc_dma.sv
module desc_dma
    import dma_pkg::*;
#(
    parameter  int LEN_W     = 16,
    parameter  int MAX_BURST = 32,
    localparam int BLEN_W    = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       stat_word,
    output logic              irq,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [1:0]        mem_req_op,
    output logic [63:0]       mem_req_haddr,
    output logic [31:0]       mem_req_laddr,
    output logic [BLEN_W-1:0] mem_req_len,
    output logic [31:0]       mem_req_wdata,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    input  logic              mem_done
);
    cfg_t             cfg;
    logic [63:0]      tbase;
    logic [IDX_W-1:0] limit;
    logic             start;
    logic             busy;
    logic             fetch_go;
    desc_t            desc;
    mem_op_e          op;
    logic [IDX_W-1:0] last_done;

    dma_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
        .busy(busy), .cfg(cfg), .tbase(tbase), .limit(limit), .start(start)
    );

    dma_desc_cap u_cap (
        .clk(clk), .rst(rst), .clr(fetch_go), .rd_valid(mem_rd_valid),
        .rd_data(mem_rd_data), .desc(desc)
    );

    dma_seq #(.LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .BLEN_W(BLEN_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .limit(limit), .cfg(cfg),
        .tbase(tbase), .desc(desc), .req_ready(mem_req_ready), .done(mem_done),
        .req_valid(mem_req_valid), .req_op(op), .req_haddr(mem_req_haddr),
        .req_laddr(mem_req_laddr), .req_len(mem_req_len), .req_wdata(mem_req_wdata),
        .busy(busy), .fetch_go(fetch_go), .last_done(last_done), .irq(irq)
    );

    assign mem_req_op = op;
    assign stat_word  = {15'd0, ~busy, last_done};

endmodule

// File: rtl/desc_dma_chk.sv
module desc_dma_chk #(
    parameter int MAX_BURST = 32,
    parameter int BLEN_W    = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [1:0]        mem_req_op,
    input logic [63:0]       mem_req_haddr,
    input logic [31:0]       mem_req_laddr,
    input logic [BLEN_W-1:0] mem_req_len,
    input logic              irq,
    input logic [31:0]       stat_word
);
    a_r13_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_op)
            && $stable(mem_req_haddr) && $stable(mem_req_laddr) && $stable(mem_req_len));

    a_r4_len_range: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_len != '0) && (32'(mem_req_len) <= MAX_BURST));

    a_r6_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_haddr[1:0] == 2'b00) && (mem_req_laddr[1:0] == 2'b00));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r10_irq_at_idle: assert property (@(posedge clk) disable iff (rst)
        irq |-> stat_word[16]);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        stat_word[16] |-> !mem_req_valid);
endmodule

bind desc_dma desc_dma_chk #(.MAX_BURST(MAX_BURST), .BLEN_W(BLEN_W)) u_chk (
    .clk(clk), .rst(rst), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_op(mem_req_op), .mem_req_haddr(mem_req_haddr), .mem_req_laddr(mem_req_laddr),
    .mem_req_len(mem_req_len), .irq(irq), .stat_word(stat_word)
);

// File: tb/desc_dma_test.sv
module desc_dma_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] stat_word;
    logic        irq;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [1:0]  mem_req_op;
    logic [63:0] mem_req_haddr;
    logic [31:0] mem_req_laddr;
    logic [5:0]  mem_req_len;
    logic [31:0] mem_req_wdata;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;
    logic        mem_done;

    always #10 clk = ~clk;

    desc_dma uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .stat_word(stat_word), .irq(irq), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_op(mem_req_op), .mem_req_haddr(mem_req_haddr),
        .mem_req_laddr(mem_req_laddr), .mem_req_len(mem_req_len), .mem_req_wdata(mem_req_wdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .mem_done(mem_done)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [63:0] h;
        logic [31:0] l;
        logic [5:0]  n;
        logic [31:0] d;
    } req_t;

    req_t        exp_q[$];
    int          checks = 0;
    int          errors = 0;
    int          irq_cnt = 0;
    int          acc_cnt = 0;
    logic [31:0] hmem [0:1023];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_req(input string tag, input req_t act, input req_t exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic req_t cur_req();
        return '{mem_req_op, mem_req_haddr, mem_req_laddr, mem_req_len, mem_req_wdata};
    endfunction

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'd0:    return "R3 descriptor fetch";
            2'd1:    return "R4 R5 host-to-local burst";
            2'd2:    return "R5 local-to-host burst";
            default: return "R9 write-back";
        endcase
    endfunction

    always @(negedge clk) if (!rst && irq) irq_cnt++;

    // memory responder and request comparison
    initial begin
        mem_req_ready = 1'b0;
        mem_rd_valid  = 1'b0;
        mem_rd_data   = '0;
        mem_done      = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && mem_req_valid) begin
                req_t first;
                req_t want;
                int   stall;
                first = cur_req();
                stall = acc_cnt % 3;
                for (int k = 0; k < stall; k++) begin
                    @(negedge clk);
                    check("R13 valid held", 64'(mem_req_valid), 64'd1);
                    check_req("R13 request stable", cur_req(), first);
                end
                check("R6 dword alignment", 64'({mem_req_haddr[1:0], mem_req_laddr[1:0]}), 64'd0);
                mem_req_ready = 1'b1;
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R7 unexpected request: actual %h expected none", first);
                end else begin
                    want = exp_q.pop_front();
                    check_req(op_tag(want.op), first, want);
                end
                acc_cnt++;
                @(negedge clk);
                mem_req_ready = 1'b0;
                if (first.op == 2'd0) begin
                    for (int k = 0; k < 4; k++) begin
                        mem_rd_valid = 1'b1;
                        mem_rd_data  = hmem[10'(first.h[11:2] + 10'(k))];
                        @(negedge clk);
                    end
                    mem_rd_valid = 1'b0;
                    mem_rd_data  = '0;
                end else begin
                    @(negedge clk);
                end
                mem_done = 1'b1;
                @(negedge clk);
                mem_done = 1'b0;
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_sel   = sel;
        reg_wdata = data;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic set_desc(input int base_idx, input int i, input logic [31:0] len,
                            input logic [31:0] loc, input logic [31:0] hh, input logic [31:0] hl);
        hmem[base_idx + 4*i]     = len;
        hmem[base_idx + 4*i + 1] = loc;
        hmem[base_idx + 4*i + 2] = hh;
        hmem[base_idx + 4*i + 3] = hl;
    endtask

    task automatic push_chain(input int first, input int last, input logic [63:0] tab,
                              input bit dir, input bit wb);
        for (int i = first; i <= last; i++) begin
            int          bi;
            int          rem;
            logic [63:0] h;
            logic [31:0] l;
            bi = int'(tab[11:2]) + 4*i;
            exp_q.push_back('{2'd0, tab + 64'(16*i), 32'd0, 6'd4, 32'd0});
            rem = int'(hmem[bi][15:0]);
            l   = {hmem[bi+1][31:2], 2'b00};
            h   = {hmem[bi+2], hmem[bi+3][31:2], 2'b00};
            while (rem > 0) begin
                int b;
                b = (rem > 32) ? 32 : rem;
                exp_q.push_back('{dir ? 2'd2 : 2'd1, h, l, 6'(b), 32'd0});
                h   = h + 64'(4*b);
                l   = l + 32'(4*b);
                rem = rem - b;
            end
            if (wb) exp_q.push_back('{2'd3, tab - 64'd4, 32'd0, 6'd1, 32'(i)});
        end
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        for (int k = 0; k < 20000 && !stat_word[16]; k++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int acc_before;
        for (int k = 0; k < 1024; k++) hmem[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 status after reset", 64'(stat_word), 64'h0001FFFF);
        check("R1 no request after reset", 64'(mem_req_valid), 64'd0);
        check("R1 irq low after reset", 64'(irq), 64'd0);

        // three-descriptor chain, write-back and interrupt on (R2 R3 R4 R5 R7 R8 R9 R10)
        set_desc(64, 0, 32'd1024, 32'h0000_1000, 32'h0000_0001, 32'h0000_0000);
        set_desc(64, 1, 32'd5,    32'h0000_2000, 32'h0,         32'h0000_8000);
        set_desc(64, 2, 32'd40,   32'h0000_3000, 32'h0,         32'h0000_9000);
        wr(2'd0, 32'h0006_0003);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0000_0100);
        push_chain(0, 2, 64'h100, 1'b0, 1'b1);
        wr(2'd3, 32'd2);
        wait_idle();
        check("R8 status after chain (R7 all indices)", 64'(stat_word), 64'h0001_0002);
        check("R10 one irq pulse for chain", 64'(irq_cnt), 64'd1);
        check("R4 all expected requests issued", 64'(exp_q.size()), 64'd0);

        // direction 1, unaligned addresses, zero length, clamp, no irq or write-back (R5 R6 R7 R9 R10 R12)
        set_desc(64, 0, 32'd0, 32'h0000_5000, 32'h0, 32'h0000_7000);
        set_desc(64, 1, 32'd3, 32'h0000_4003, 32'h0, 32'h0000_A002);
        set_desc(64, 2, 32'd7, 32'h0000_6000, 32'h0, 32'h0000_B000);
        wr(2'd0, 32'h0001_0002);
        wr(2'd2, 32'h0000_0102);
        push_chain(0, 1, 64'h100, 1'b1, 1'b0);
        wr(2'd3, 32'd5);
        wait_idle();
        check("R7 clamp stops at count-1, R12 zero length completes", 64'(stat_word), 64'h0001_0001);
        check("R10 no irq when disabled", 64'(irq_cnt), 64'd1);
        check("R5 R6 R9 expected requests issued", 64'(exp_q.size()), 64'd0);

        // count zero: start ignored (R7)
        wr(2'd0, 32'h0000_0000);
        acc_before = acc_cnt;
        wr(2'd3, 32'd0);
        repeat (20) @(negedge clk);
        check("R7 count zero write ignored (status)", 64'(stat_word), 64'h0001_0001);
        check("R7 count zero write ignored (requests)", 64'(acc_cnt), 64'(acc_before));

        // extension while busy (R11 R8)
        set_desc(64, 0, 32'd1024, 32'h0000_1000, 32'h0000_0001, 32'h0000_0000);
        set_desc(64, 1, 32'd5,    32'h0000_2000, 32'h0,         32'h0000_8000);
        set_desc(64, 2, 32'd40,   32'h0000_3000, 32'h0,         32'h0000_9000);
        wr(2'd0, 32'h0004_0004);
        wr(2'd2, 32'h0000_0100);
        push_chain(0, 0, 64'h100, 1'b0, 1'b0);
        wr(2'd3, 32'd0);
        repeat (12) @(negedge clk);
        check("R8 pending while busy", 64'(stat_word[16]), 64'd0);
        push_chain(1, 2, 64'h100, 1'b0, 1'b0);
        wr(2'd3, 32'd2);
        wait_idle();
        check("R11 extended chain ends at new index", 64'(stat_word), 64'h0001_0002);
        check("R11 one irq for extended chain", 64'(irq_cnt), 64'd2);
        check("R11 no restart, all requests matched", 64'(exp_q.size()), 64'd0);

        summary();
        $finish;
    end

endmodule